// File: doc/BRIEF.md
# Random Word Generator with Fault Recovery

This block is a register-mapped random word source. A 32-bit shift-register generator stands in for a physical noise source. Its words are pushed into a four-word output queue at a fixed refill rate, and software pulls them out one per read of the data register. A ready flag in the status register tells software that at least one word can be taken.

A fault input models a failure of the noise source. While the fault is present, the block produces no words and throws away everything queued. It also latches a sticky fault flag, which can raise an interrupt. Recovery has two steps. Software first clears the flag by writing a zero to its status bit. It then reads the data register twelve times and discards the results. These discard reads stand for flushing the conditioning pipeline. Once the twelfth discard read is done, generation starts again.

Control is at byte offset 0x0, status at 0x4 and data at 0x8. Bus accesses take one cycle. Read data is valid in the same cycle as the access.

Top module: `rng_core`

## Requirements
- R1: After reset, the control register, the status register and `irq` are all 0, and a data read returns 0.
- R2: Control register bits: bit 2 is the generator enable, bit 3 is the interrupt enable and bit 5 is the clock-check disable. Only these bits are stored. All other control bits always read as 0.
- R3: Enabling the generator places the first word in the queue on the 8th clock edge after the enabling write. Status bit 0 (ready) is 1 from then on, and the queue fills to at most 4 words. The words are successive states of a 32-bit Galois generator that starts at 0x00000001: next = (s >> 1) ^ (s[0] ? 0xA3000000 : 0). The current state is queued first, then the generator advances.
- R4: Each read of the data register pops one queued word, in queue order. A read from an empty queue returns 0, so exactly 4 reads of a full queue return words.
- R5: Writing 0 to the control register stops generation. Words already queued remain readable, and no new words appear.
- R6: While the fault input is high, status bit 2 reads 1 and ready reads 0. Each edge with the fault input high sets status bit 6 (the sticky fault flag) and empties the queue.
- R7: A status write with bit 6 = 0 clears the fault flag. A status write with bit 6 = 1 leaves the flag set.
- R8: After the flag is cleared, exactly 12 data reads return 0 and no words are produced. Data reads made while the flag is still set do not count toward the 12. The 12th read restarts generation, and the first new word arrives 8 edges later.
- R9: If the fault is present again during the flush or during the clear, the flag sets again and a full new flush of 12 reads is needed.
- R10: `irq` is 1 exactly when the interrupt enable is 1 and the fault flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address: 0x0 control, 0x4 status, 0x8 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| seed_fault | input | 1 | Noise source fault, level sensitive |
| irq | output | 1 | Interrupt request |

## Verification
A wrong flush counter is visible at the ports as a change in the number of zero reads needed before ready returns. The bench finds this within eight edges of the twelfth read, because it samples ready both just before and just after the first refill edge. A queue pointer or count that drifts makes a data read return a word that differs from the generator sequence predicted by the bench, or a zero where a word was expected, on the very read concerned. A flag that fails to set or to clear shows in the same cycle in status bit 6 and in `irq`.

// File: rtl/rng_core.sv
module rng_core #(
  parameter int          DEPTH  = 4,
  parameter int          REFILL = 8,
  parameter int          FLUSH  = 12,
  parameter logic [31:0] SEED   = 32'h0000_0001,
  parameter logic [31:0] POLY   = 32'hA300_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        seed_fault,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(REFILL);
  localparam int DW = $clog2(FLUSH + 1);

  logic          gen_en, irq_en, clk_chk_off, err_flag;
  logic [31:0]   lfsr;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic [DW-1:0] drain;

  wire acc_ctrl = bus_sel && bus_addr[3:2] == 2'd0;
  wire acc_stat = bus_sel && bus_addr[3:2] == 2'd1;
  wire acc_data = bus_sel && bus_addr[3:2] == 2'd2;
  wire wr_ctrl  = acc_ctrl && bus_wr;
  wire clr_wr   = acc_stat && bus_wr && !bus_wdata[6];
  wire rd_data  = acc_data && !bus_wr;

  wire drained = drain == '0;
  wire gen_ok  = gen_en && drained && !seed_fault;
  wire full    = cnt == CW'(DEPTH);
  wire pop     = rd_data && cnt != '0 && drained;
  wire push    = gen_ok && tmr == TW'(REFILL - 1) && (!full || pop);
  wire ready   = cnt != '0 && !seed_fault;

  wire [31:0] ctrl_q = {26'b0, clk_chk_off, 1'b0, irq_en, gen_en, 2'b0};
  wire [31:0] stat_q = {25'b0, err_flag, 3'b0, seed_fault, 1'b0, ready};
  wire unused_bits   = ^{bus_addr[1:0], bus_wdata[31:7], bus_wdata[4], bus_wdata[1:0]};

  assign irq = irq_en && err_flag;

  always_comb begin
    bus_rdata = '0;
    if (acc_ctrl && !bus_wr) bus_rdata = ctrl_q;
    if (acc_stat && !bus_wr) bus_rdata = stat_q;
    if (pop)                 bus_rdata = mem[rp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      irq_en <= 1'b0;
      clk_chk_off <= 1'b0;
    end else if (wr_ctrl) begin
      gen_en <= bus_wdata[2];
      irq_en <= bus_wdata[3];
      clk_chk_off <= bus_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      drain    <= '0;
    end else if (seed_fault) begin
      err_flag <= 1'b1;
      drain    <= DW'(FLUSH);
    end else begin
      if (clr_wr) err_flag <= 1'b0;
      if (rd_data && !drained && !err_flag) drain <= drain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tmr <= '0;
    else if (!gen_ok || push)        tmr <= '0;
    else if (tmr != TW'(REFILL - 1)) tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr <= SEED;
    else if (push) lfsr <= (lfsr >> 1) ^ (lfsr[0] ? POLY : 32'h0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (seed_fault) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= lfsr;
  end
endmodule

module rng_core_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  parameter int DW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seed_fault,
  input logic          irq,
  input logic          irq_en,
  input logic          flag,
  input logic          clr_wr,
  input logic [CW-1:0] cnt,
  input logic [DW-1:0] drain
);
  assert_fifo_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_fault_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seed_fault |=> flag);
  assert_flag_clears_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_wr));
  assert_flush_keeps_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain != '0) |-> (cnt == '0));
  assert_flush_counts_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain != '0 && !seed_fault) |=> (drain <= $past(drain)));
  assert_irq_on_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && $rose(flag)) |-> irq);
endmodule

bind rng_core rng_core_chk #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_fault(seed_fault), .irq(irq), .irq_en(irq_en),
  .flag(err_flag), .clr_wr(clr_wr), .cnt(cnt), .drain(drain)
);

// File: tb/rng_core_tb.sv
`timescale 1ns/1ps
module rng_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, seed_fault = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_lfsr = 32'h1;
  logic [31:0] mq[$];
  logic [31:0] v;

  always #10 clk = ~clk;

  rng_core u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seed_fault(seed_fault), .irq(irq));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'hA300_0000 : 32'h0);
  endfunction

  task automatic top_up();
    while (mq.size() < 4) begin
      mq.push_back(m_lfsr);
      m_lfsr = nxt(m_lfsr);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic br(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_exp(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    br(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse_fault();
    seed_fault = 1;
    @(negedge clk);
    seed_fault = 0;
    mq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    v = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_exp("R1 ctrl", 4'h0, 32'h0);
    rd_exp("R1 status", 4'h4, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_exp("R1 data", 4'h8, 32'h0);

    bw(4'h0, 32'h24);
    repeat (7) @(negedge clk);
    rd_exp("R3 not ready before 8th edge", 4'h4, 32'h0);
    rd_exp("R3 ready at 8th edge", 4'h4, 32'h1);
    repeat (40) @(negedge clk);
    top_up();

    bw(4'h0, 32'h0);
    for (int i = 0; i < 4; i++) rd_exp("R4 pop order", 4'h8, mq.pop_front());
    rd_exp("R4 empty read", 4'h8, 32'h0);
    repeat (40) @(negedge clk);
    rd_exp("R5 no words after disable", 4'h4, 32'h0);

    bw(4'h0, 32'hFFFF_FFD3);
    rd_exp("R2 unused bits read 0", 4'h0, 32'h0);
    bw(4'h0, 32'h28);
    rd_exp("R2 stored bits", 4'h0, 32'h28);
    chk("R10 no irq without flag", {31'b0, irq}, 32'h0);

    bw(4'h0, 32'h24);
    for (int it = 0; it < 12; it++) begin
      repeat (40) @(negedge clk);
      top_up();
      for (int k = $urandom_range(1, 4); k > 0; k--) begin
        rd_exp("R3 sequence", 4'h8, mq.pop_front());
        repeat ($urandom_range(0, 3)) @(negedge clk);
      end
    end

    repeat (40) @(negedge clk);
    top_up();
    seed_fault = 1;
    rd_exp("R6 fault status", 4'h4, 32'h04);
    seed_fault = 0;
    mq.delete();
    rd_exp("R6 sticky flag", 4'h4, 32'h40);
    chk("R10 masked", {31'b0, irq}, 32'h0);
    bw(4'h0, 32'h2C);
    chk("R10 irq raised", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 3; i++) rd_exp("R8 read before clear", 4'h8, 32'h0);
    bw(4'h4, 32'hFFFF_FFFF);
    rd_exp("R7 write 1 keeps flag", 4'h4, 32'h40);
    bw(4'h4, 32'h0);
    rd_exp("R7 write 0 clears", 4'h4, 32'h0);
    chk("R10 irq dropped", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 11; i++) rd_exp("R8 discard read", 4'h8, 32'h0);
    repeat (40) @(negedge clk);
    rd_exp("R8 no output after 11 reads", 4'h4, 32'h0);
    rd_exp("R8 12th discard", 4'h8, 32'h0);
    repeat (7) @(negedge clk);
    rd_exp("R8 not ready before 8th edge", 4'h4, 32'h0);
    rd_exp("R8 ready again", 4'h4, 32'h1);
    top_up();
    rd_exp("R8 sequence resumes", 4'h8, mq.pop_front());

    repeat (40) @(negedge clk);
    top_up();
    pulse_fault();
    bw(4'h4, 32'h0);
    for (int i = 0; i < 6; i++) rd_exp("R9 partial flush", 4'h8, 32'h0);
    seed_fault = 1;
    bw(4'h4, 32'h0);
    seed_fault = 0;
    rd_exp("R9 flag set again", 4'h4, 32'h40);
    chk("R9 irq again", {31'b0, irq}, 32'h1);
    bw(4'h4, 32'h0);
    for (int i = 0; i < 11; i++) rd_exp("R9 new flush", 4'h8, 32'h0);
    repeat (20) @(negedge clk);
    rd_exp("R9 still flushing", 4'h4, 32'h0);
    rd_exp("R9 last discard", 4'h8, 32'h0);
    repeat (40) @(negedge clk);
    top_up();
    rd_exp("R9 ready after full flush", 4'h4, 32'h1);
    for (int i = 0; i < 4; i++) rd_exp("R9 sequence", 4'h8, mq.pop_front());

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule